// File: doc/BRIEF.md
# At-Speed Transition Test Clock Sequencer

This block runs one scan-based transition delay test on chip. A slow shift clock comes from the tester and a fast functional clock comes from the on-chip clock source. The block merges them into a single gated test clock for the scan flip-flops and drives their scan-enable. After a start strobe it shifts a pattern in on the slow clock. It then fires two fast edges one functional period apart: the first launches the transition and the second captures the response. It waits at least two idle slow periods and then shifts the result out on the slow clock. A one-slow-period done pulse marks the end of the test.

Two launch styles are supported. With launch-from-shift, the launch edge still sees scan-enable high, so the transition comes from the scan path. Scan-enable must fall inside the single fast period before the capture edge. With launch-from-capture, one extra slow edge with scan-enable low first loads the system-side value. Both fast edges then come from the functional path, and the timing of scan-enable no longer matters. All control logic runs on the fast clock. The slow clock is synchronised only to find its falling edges, and every gating change is made while the clock being gated is low. For this to work, each phase of the slow clock must last longer than the synchroniser depth plus four fast periods.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: A synchronous active-low reset, sampled on the fast clock, returns the block to idle. Scan-enable and done go low and the test clock stays low and produces no edges until the next start.
- R2: A start seen in idle raises scan-enable on the next fast edge and captures the shift length. Exactly that many slow-clock test edges are then issued with scan-enable high before the dynamic phase.
- R3: With mode input 0 (launch-from-shift), no extra slow edge follows the load. The launch edge sees scan-enable high and the capture edge sees it low.
- R4: With mode input 1 (launch-from-capture), one slow edge with scan-enable low follows the load. Both fast edges then see scan-enable low.
- R5: The dynamic phase is exactly two test-clock edges taken from the fast clock, one fast period apart, both while the slow clock is low.
- R6: Scan-enable rises again for unload no sooner than two slow-clock periods after the capture edge.
- R7: Unload issues exactly the captured shift length of slow test edges, all with scan-enable high. Scan-enable then drops.
- R8: Done goes high once per test, after the last unload edge, and stays high for exactly one slow-clock period.
- R9: A start, or a change of the mode or shift-length inputs, while a test is running has no effect on the running test.
- R10: The test clock never produces a high pulse shorter than half a fast period, and its two sources are never enabled together.
- R11: A shift length of zero skips both shift phases but still runs the launch and capture edges and the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast functional clock; all control logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Slow tester shift clock |
| start | input | 1 | Begins a test when the block is idle |
| lc_mode | input | 1 | 0 = launch-from-shift, 1 = launch-from-capture |
| shift_len | input | CNT_W | Number of shift edges for load and for unload |
| test_clk | output | 1 | Gated test clock to the scan flip-flops |
| scan_en | output | 1 | Scan-enable to the scan flip-flops |
| done | output | 1 | One-slow-period pulse at the end of a test |

## Verification
The bench goes after the scan-enable value at each of the two fast edges in both modes. A design that dropped scan-enable a cycle late would capture from the scan path, and one that kept it high in the extra init slot would launch from the wrong side. Zero-length shifts, start pulses and input changes in the middle of a test, and a reset in the middle of a load are all driven. Wrong behaviour would show up as extra or missing test-clock edges, a second done pulse, or scan-enable stuck high. Every edge time, edge spacing and pulse width is measured, which catches a third fast edge, fast edges wider than one period, truncated pulses, or an unload that begins before the two idle slow periods.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_INIT,
      ST_PAIR,
      ST_GAP,
      ST_UNLOAD,
      ST_DONE
   } dtc_state_e;

   typedef enum logic {
      LAUNCH_SHIFT   = 1'b0,
      LAUNCH_CAPTURE = 1'b1
   } launch_e;
endpackage

// File: rtl/dtc_edge_sync.sv
`timescale 1ns/1ps
module dtc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_tick
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("dtc_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] stg_q;
   logic                   prev_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= 1'b0;
            else        stg_q[g] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= 1'b0;
            else        stg_q[g] <= stg_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= stg_q[LAST];
   end

   assign fall_tick = prev_q & ~stg_q[LAST];

   AST_TICK_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_tick |=> !fall_tick); // R10
endmodule

// File: rtl/dtc_clk_gate.sv
`timescale 1ns/1ps
module dtc_clk_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_clk,
   input  logic fast_req,
   input  logic slow_en,
   output logic test_clk
);
   logic fgate_q;

   // Fast enable is retimed on the falling edge, so it only moves while clk is low.
   always_ff @(negedge clk) begin
      if (!rst_n) fgate_q <= 1'b0;
      else        fgate_q <= fast_req;
   end

   // slow_en is only changed by the sequencer while shift_clk is low.
   assign test_clk = (clk & fgate_q) | (shift_clk & slow_en);

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fgate_q && slow_en)); // R10
endmodule

// File: rtl/dtc_seq.sv
`timescale 1ns/1ps
module dtc_seq
   import dtc_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int IDLE_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             lc_mode,
   input  logic [CNT_W-1:0] shift_len,
   input  logic             fall_tick,
   output logic             scan_en,
   output logic             fast_req,
   output logic             slow_en,
   output logic             done
);
   localparam int GAP_W = $clog2(IDLE_GAP + 1);

   if (IDLE_GAP < 2) begin : g_bad_gap
      $error("dtc_seq: IDLE_GAP must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dtc_seq: CNT_W must be at least 1");
   end

   dtc_state_e       state_q;
   launch_e          mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic [GAP_W-1:0] gap_q;
   logic             pair_q;
   logic             scan_en_q;
   logic             fast_req_q;
   logic             slow_en_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= LAUNCH_SHIFT;
         cnt_q      <= '0;
         len_q      <= '0;
         gap_q      <= '0;
         pair_q     <= 1'b0;
         scan_en_q  <= 1'b0;
         fast_req_q <= 1'b0;
         slow_en_q  <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q   <= ST_LOAD;
                  scan_en_q <= 1'b1;
                  cnt_q     <= shift_len;
                  len_q     <= shift_len;
                  mode_q    <= launch_e'(lc_mode);
               end
            end
            ST_LOAD: begin
               if (fall_tick) begin
                  if (cnt_q != '0) begin
                     slow_en_q <= 1'b1;
                     cnt_q     <= cnt_q - CNT_W'(1);
                  end else if (mode_q == LAUNCH_CAPTURE) begin
                     slow_en_q <= 1'b1;
                     scan_en_q <= 1'b0;
                     state_q   <= ST_INIT;
                  end else begin
                     slow_en_q  <= 1'b0;
                     fast_req_q <= 1'b1;
                     pair_q     <= 1'b0;
                     state_q    <= ST_PAIR;
                  end
               end
            end
            ST_INIT: begin
               if (fall_tick) begin
                  slow_en_q  <= 1'b0;
                  fast_req_q <= 1'b1;
                  pair_q     <= 1'b0;
                  state_q    <= ST_PAIR;
               end
            end
            ST_PAIR: begin
               if (!pair_q) begin
                  pair_q    <= 1'b1;
                  scan_en_q <= 1'b0;
               end else begin
                  fast_req_q <= 1'b0;
                  gap_q      <= '0;
                  state_q    <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (fall_tick) begin
                  if (gap_q == GAP_W'(IDLE_GAP)) begin
                     scan_en_q <= 1'b1;
                     cnt_q     <= len_q;
                     state_q   <= ST_UNLOAD;
                  end else begin
                     gap_q <= gap_q + GAP_W'(1);
                  end
               end
            end
            ST_UNLOAD: begin
               if (fall_tick) begin
                  if (cnt_q != '0) begin
                     slow_en_q <= 1'b1;
                     cnt_q     <= cnt_q - CNT_W'(1);
                  end else begin
                     slow_en_q <= 1'b0;
                     scan_en_q <= 1'b0;
                     done_q    <= 1'b1;
                     state_q   <= ST_DONE;
                  end
               end
            end
            ST_DONE: begin
               if (fall_tick) begin
                  done_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign scan_en  = scan_en_q;
   assign fast_req = fast_req_q;
   assign slow_en  = slow_en_q;
   assign done     = done_q;

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (!scan_en_q && !done_q && !fast_req_q && !slow_en_q)); // R1
   AST_PAIR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_req_q && $past(fast_req_q)) |=> !fast_req_q); // R5
   AST_LAUNCH_SE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_req_q) |-> (scan_en_q == (mode_q == LAUNCH_SHIFT))); // R3
   AST_CAPTURE_SE: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_req_q && $past(fast_req_q)) |-> !scan_en_q); // R4
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(len_q) && $stable(mode_q)); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (!scan_en_q && !slow_en_q && !fast_req_q)); // R8
endmodule

// File: rtl/atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_GAP    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_clk,
   input  logic             start,
   input  logic             lc_mode,
   input  logic [CNT_W-1:0] shift_len,
   output logic             test_clk,
   output logic             scan_en,
   output logic             done
);
   logic fall_tick;
   logic fast_req;
   logic slow_en;

   dtc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (shift_clk),
      .fall_tick (fall_tick)
   );

   dtc_seq #(.CNT_W(CNT_W), .IDLE_GAP(IDLE_GAP)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .lc_mode   (lc_mode),
      .shift_len (shift_len),
      .fall_tick (fall_tick),
      .scan_en   (scan_en),
      .fast_req  (fast_req),
      .slow_en   (slow_en),
      .done      (done)
   );

   dtc_clk_gate i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_clk (shift_clk),
      .fast_req  (fast_req),
      .slow_en   (slow_en),
      .test_clk  (test_clk)
   );
endmodule

// File: tb/test_atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module test_atspeed_clk_ctrl;
   localparam int CNT_W = 8;
   localparam real TSLOW = 200.0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             shift_clk = 1'b0;
   logic             start = 1'b0;
   logic             lc_mode = 1'b0;
   logic [CNT_W-1:0] shift_len = '0;
   logic             test_clk;
   logic             scan_en;
   logic             done;

   int n_chk = 0;
   int n_err = 0;

   atspeed_clk_ctrl #(.CNT_W(CNT_W)) i_atspeed_clk_ctrl (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .start(start),
      .lc_mode(lc_mode), .shift_len(shift_len), .test_clk(test_clk),
      .scan_en(scan_en), .done(done)
   );

   always #5 clk = ~clk;
   initial begin
      #3;
      forever #100 shift_clk = ~shift_clk;
   end

   // Monitors
   logic    se_neg = 1'b0;
   int      n_edge;
   realtime e_t [64];
   logic    e_se[64];
   logic    e_sh[64];
   realtime last_rise, min_w, done_r, done_f, se_rise_t;
   int      n_done;

   always @(negedge clk) se_neg = scan_en;
   always @(posedge test_clk) begin
      if (n_edge < 64) begin
         e_t[n_edge]  = $realtime;
         e_se[n_edge] = se_neg;
         e_sh[n_edge] = shift_clk;
      end
      n_edge++;
      last_rise = $realtime;
   end
   always @(negedge test_clk) if ($realtime - last_rise < min_w) min_w = $realtime - last_rise;
   always @(posedge done) begin n_done++; done_r = $realtime; end
   always @(negedge done) done_f = $realtime;
   always @(posedge scan_en) se_rise_t = $realtime;

   task automatic clear_mon();
      n_edge = 0; n_done = 0; min_w = 1.0e9; last_rise = $realtime;
      done_r = 0; done_f = 0; se_rise_t = 0;
   endtask

   task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0g expected=%0g", req, what, act, exp);
      end
   endtask

   function automatic bit near(input real a, input real b);
      return (a - b < 0.01) && (b - a < 0.01);
   endfunction

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1'b1; break; end
      end
      if (ok) while (done) @(negedge clk);
      repeat (50) @(negedge clk);
   endtask

   task automatic run_seq(input logic mode, input int len, input bit poke);
      bit ok;
      int exp_n, rel, cap;
      bit all1;
      clear_mon();
      @(negedge clk);
      lc_mode = mode; shift_len = CNT_W'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(scan_en == 1'b1, "R2", "scan_en after start", scan_en, 1);
      if (poke) begin
         repeat (50) @(negedge clk);
         shift_len = CNT_W'(len + 5); lc_mode = ~mode; start = 1'b1;
         @(negedge clk); start = 1'b0;
         repeat (100) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      wait_done(ok);
      shift_len = CNT_W'(len); lc_mode = mode;
      chk(ok, "R8", "done seen", ok, 1);
      exp_n = 2 * len + 2 + int'(mode);
      chk(n_edge == exp_n, poke ? "R9" : (len == 0 ? "R11" : "R2"), "edge count", n_edge, exp_n);
      chk(n_done == 1, poke ? "R9" : "R8", "done pulse count", n_done, 1);
      if (n_edge != exp_n) return;
      rel = len + int'(mode);
      cap = rel + 1;
      all1 = 1'b1;
      for (int i = 0; i < len; i++) all1 &= e_se[i];
      chk(all1, "R2", "scan_en high on load edges", all1, 1);
      if (mode) begin
         chk(e_se[len] == 1'b0, "R4", "scan_en on init edge", e_se[len], 0);
         chk(e_se[rel] == 1'b0 && e_se[cap] == 1'b0, "R4", "scan_en on launch/capture",
             {e_se[rel], e_se[cap]}, 0);
      end else begin
         chk(e_se[rel] == 1'b1, "R3", "scan_en on launch edge", e_se[rel], 1);
         chk(e_se[cap] == 1'b0, "R3", "scan_en on capture edge", e_se[cap], 0);
      end
      chk(near(e_t[cap] - e_t[rel], 10.0), "R5", "launch-capture spacing", e_t[cap] - e_t[rel], 10.0);
      chk(e_sh[rel] == 1'b0 && e_sh[cap] == 1'b0, "R5", "shift_clk low at fast edges",
          {e_sh[rel], e_sh[cap]}, 0);
      if (rel > 0)
         chk(e_t[rel] - e_t[rel-1] >= TSLOW / 2.0, "R5", "no extra fast edge before launch",
             e_t[rel] - e_t[rel-1], TSLOW / 2.0);
      if (cap + 1 < n_edge)
         chk(e_t[cap+1] - e_t[cap] >= 2.0 * TSLOW, "R5", "no extra edge after capture",
             e_t[cap+1] - e_t[cap], 2.0 * TSLOW);
      chk(se_rise_t - e_t[cap] >= 2.0 * TSLOW, "R6", "idle gap before unload",
          se_rise_t - e_t[cap], 2.0 * TSLOW);
      all1 = 1'b1;
      for (int i = cap + 1; i < n_edge; i++) all1 &= e_se[i];
      chk(all1, "R7", "scan_en high on unload edges", all1, 1);
      chk(scan_en == 1'b0, "R7", "scan_en low after unload", scan_en, 0);
      chk(near(done_f - done_r, TSLOW), "R8", "done width", done_f - done_r, TSLOW);
      chk(done_r > e_t[n_edge-1], "R8", "done after last edge", done_r, e_t[n_edge-1]);
      chk(min_w >= 5.0, "R10", "minimum test_clk pulse", min_w, 5.0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(scan_en == 1'b0, "R1", "scan_en in reset", scan_en, 0);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      rst_n = 1'b1;
      clear_mon();
      repeat (40) @(negedge clk);
      chk(n_edge == 0, "R1", "no edges while idle", n_edge, 0);
   endtask

   task automatic t_mid_reset();
      clear_mon();
      @(negedge clk);
      lc_mode = 1'b1; shift_len = CNT_W'(6); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (70) @(negedge clk);
      chk(n_edge > 0, "R2", "load underway before reset", n_edge, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(scan_en == 1'b0, "R1", "scan_en after mid reset", scan_en, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clear_mon();
      repeat (80) @(negedge clk);
      chk(n_edge == 0 && scan_en == 1'b0 && done == 1'b0, "R1", "quiet after mid reset",
          n_edge + scan_en + done, 0);
   endtask

   initial begin
      t_reset();
      run_seq(1'b0, 5, 1'b0);
      run_seq(1'b1, 3, 1'b0);
      run_seq(1'b0, 0, 1'b0);
      run_seq(1'b1, 0, 1'b0);
      run_seq(1'b0, 4, 1'b1);
      t_mid_reset();
      run_seq(1'b1, 2, 1'b0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule